// File: doc/BRIEF.md
# Delayed Video-Memory Write Queue

This block sits between a host data port and three on-chip memories: a byte-wide video RAM, a 16-bit color RAM and a 16-bit vertical-scroll RAM. A host word offered on the data port is accepted into a small queue together with the current destination address, the current write code, a partial flag and the slot count at which it becomes ready. The current address then advances by a programmable step, so a host can stream consecutive words after loading one start address.

The queue is drained by the external access slots of the video timing, which arrive as one-cycle `slot_tick` pulses. An entry may retire only once a fixed number of slots has passed since it was queued. A video RAM word needs two slots: the first writes its high byte and marks the entry partial, and the second writes the low byte at the neighbouring odd/even address and removes the entry. A color RAM or scroll RAM word retires in one slot. Any slot that finds nothing ready to retire is reported as unused, so that other agents can take it. The last accepted host word is held on an output for a fill engine.

Top module: `vid_write_queue`

## Requirements
- R1: After reset the queue is empty, `h_ready` is 1, `slot_unused` is 0, `last_value` is 0 and no memory write strobe is high.
- R2: A host word offered while `wr_code[0]` is 0 (a read code) is discarded: nothing is queued, the current address does not move and `last_value` keeps its value.
- R3: Each accepted host word is stored with the current address, and the current address then advances by `auto_inc`, modulo 2^16. `addr_load` replaces the current address with `addr_value`.
- R4: An entry may retire no earlier than the third `slot_tick` counted from the clock edge that accepted it (that edge included); earlier slots leave it in the queue.
- R5: With write code 1 (video RAM), the first retiring slot writes `value[15:8]` at the stored address and keeps the entry; the next slot writes `value[7:0]` at the stored address with bit 0 inverted and removes the entry.
- R6: With write code 3 (color RAM), one slot writes the 16-bit value at word index (address >> 1) mod 64 and removes the entry.
- R7: With write code 5 (scroll RAM), one slot removes the entry and writes the value at word index (address >> 1) mod 64 only when that index is below 40; otherwise no write is made.
- R8: `slot_unused` is updated only on a `slot_tick` edge: it becomes 1 when the queue is empty or its head is not yet ready, and 0 when the slot retires (or half-retires) an entry. It holds between ticks.
- R9: With 4 entries queued `h_ready` is 0 for write codes and no word is accepted; it returns to 1 after the slot edge that removes an entry.
- R10: `last_value` equals the most recently accepted host word.
- R11: Memory write strobes rise only in the cycle after a `slot_tick` edge, last one cycle, and at most one of the three is high at a time; entries retire in the order they were accepted.
- R12: Any other odd write code consumes its retiring slot (`slot_unused` 0) and removes the entry without driving any write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | One-cycle pulse marking an external access slot |
| h_valid | input | 1 | Host offers a data word |
| h_ready | output | 1 | Queue can take a word (always 1 for read codes) |
| h_data | input | 16 | Host data word |
| wr_code | input | 4 | Access code: bit 0 set means write; 1 video RAM, 3 color RAM, 5 scroll RAM |
| addr_load | input | 1 | Load the current address from `addr_value` |
| addr_value | input | 16 | New current address |
| auto_inc | input | 8 | Address step added after each accepted word |
| vram_we | output | 1 | Video RAM byte write strobe |
| vram_addr | output | 16 | Video RAM byte address |
| vram_data | output | 8 | Video RAM byte data |
| cram_we | output | 1 | Color RAM write strobe |
| cram_addr | output | 6 | Color RAM word index |
| cram_data | output | 16 | Color RAM data |
| vsram_we | output | 1 | Scroll RAM write strobe |
| vsram_addr | output | 6 | Scroll RAM word index |
| vsram_data | output | 16 | Scroll RAM data |
| slot_unused | output | 1 | Last slot retired nothing |
| last_value | output | 16 | Most recently accepted host word |

## Verification
The bound checker watches the properties that hold in every cycle: the write strobes are mutually exclusive and only follow a slot pulse, no strobe accompanies an unused slot, `slot_unused` moves only on slot edges, the fill level never exceeds the depth, a stalled host always sees a full queue, and a discarded read-code word leaves `last_value` alone. What the checker cannot see is whether the right byte lands at the right address in the right slot; the bench shows this by sweeping addresses and values for each target, counting slots to the exact retirement edge, walking the scroll index across its 40-word limit, wrapping the address counter, and filling the queue until the host stalls.

// File: rtl/vwq_pkg.sv
package vwq_pkg;

    localparam int DATA_W  = 16;
    localparam int ADDR_W  = 16;
    localparam int CODE_W  = 4;
    localparam int STAMP_W = 8;
    localparam int IDX_W   = 6;

    localparam logic [CODE_W-1:0] CODE_VRAM  = 4'h1;
    localparam logic [CODE_W-1:0] CODE_CRAM  = 4'h3;
    localparam logic [CODE_W-1:0] CODE_VSRAM = 4'h5;

    typedef struct packed {
        logic [STAMP_W-1:0] ready_at;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  value;
        logic [CODE_W-1:0]  code;
        logic               partial;
    } qent_t;

    // True once slot count 'now' has reached 'stamp', tolerant of wrap.
    function automatic logic stamp_reached(input logic [STAMP_W-1:0] now,
                                           input logic [STAMP_W-1:0] stamp);
        logic [STAMP_W-1:0] diff;
        diff = now - stamp;
        return !diff[STAMP_W-1];
    endfunction

    function automatic logic is_write(input logic [CODE_W-1:0] code);
        return code[0];
    endfunction

endpackage

// File: rtl/vwq_fifo.sv
module vwq_fifo
    import vwq_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  qent_t            push_ent,
    input  logic             pop,
    input  logic             mark_partial,
    output qent_t            head,
    output logic             head_valid,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    qent_t            slots [DEPTH];
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign head       = slots[rd_ptr];
    assign head_valid = (level != '0);
    assign full       = (level == LVL_W'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_ent;
                wr_ptr        <= ptr_next(wr_ptr);
            end
            if (mark_partial) begin
                slots[rd_ptr].partial <= 1'b1;
            end
            if (pop) begin
                rd_ptr <= ptr_next(rd_ptr);
            end
            level <= level + LVL_W'(push) - LVL_W'(pop);
        end
    end

endmodule

// File: rtl/vwq_host.sv
module vwq_host
    import vwq_pkg::*;
#(
    parameter int LATENCY = 3,
    parameter int INC_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               h_valid,
    output logic               h_ready,
    input  logic [DATA_W-1:0]  h_data,
    input  logic [CODE_W-1:0]  wr_code,
    input  logic               addr_load,
    input  logic [ADDR_W-1:0]  addr_value,
    input  logic [INC_W-1:0]   auto_inc,
    input  logic               q_full,
    input  logic [STAMP_W-1:0] slot_cnt,
    output logic               push,
    output qent_t              push_ent,
    output logic [DATA_W-1:0]  last_value
);
    logic [ADDR_W-1:0] cur_addr;

    assign h_ready = !q_full || !is_write(wr_code);
    assign push    = h_valid && is_write(wr_code) && !q_full;

    always_comb begin
        push_ent.ready_at = slot_cnt + STAMP_W'(LATENCY);
        push_ent.addr     = cur_addr;
        push_ent.value    = h_data;
        push_ent.code     = wr_code;
        push_ent.partial  = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_addr   <= '0;
            last_value <= '0;
        end else begin
            if (addr_load) begin
                cur_addr <= addr_value;
            end else if (push) begin
                cur_addr <= cur_addr + ADDR_W'(auto_inc);
            end
            if (push) begin
                last_value <= h_data;
            end
        end
    end

endmodule

// File: rtl/vwq_retire.sv
module vwq_retire
    import vwq_pkg::*;
#(
    parameter int CRAM_WORDS  = 64,
    parameter int VSRAM_WORDS = 40,
    localparam int CRAM_AW    = $clog2(CRAM_WORDS)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_tick,
    input  qent_t              head,
    input  logic               head_valid,
    output logic               pop,
    output logic               mark_partial,
    output logic [STAMP_W-1:0] slot_cnt,
    output logic               vram_we,
    output logic [ADDR_W-1:0]  vram_addr,
    output logic [7:0]         vram_data,
    output logic               cram_we,
    output logic [CRAM_AW-1:0] cram_addr,
    output logic [DATA_W-1:0]  cram_data,
    output logic               vsram_we,
    output logic [IDX_W-1:0]   vsram_addr,
    output logic [DATA_W-1:0]  vsram_data,
    output logic               slot_unused
);
    logic               head_ready;
    logic               retire;
    logic               is_vram;
    logic [IDX_W-1:0]   vs_idx;
    logic [CRAM_AW-1:0] cr_idx;

    assign head_ready = head_valid && stamp_reached(slot_cnt + 1'b1, head.ready_at);
    assign retire     = slot_tick && head_ready;
    assign is_vram    = (head.code == CODE_VRAM);
    assign vs_idx     = head.addr[IDX_W:1];
    assign cr_idx     = head.addr[CRAM_AW:1];

    assign mark_partial = retire && is_vram && !head.partial;
    assign pop          = retire && !(is_vram && !head.partial);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_cnt    <= '0;
            slot_unused <= 1'b0;
            vram_we     <= 1'b0;
            cram_we     <= 1'b0;
            vsram_we    <= 1'b0;
            vram_addr   <= '0;
            vram_data   <= '0;
            cram_addr   <= '0;
            cram_data   <= '0;
            vsram_addr  <= '0;
            vsram_data  <= '0;
        end else begin
            vram_we  <= 1'b0;
            cram_we  <= 1'b0;
            vsram_we <= 1'b0;
            if (slot_tick) begin
                slot_cnt    <= slot_cnt + 1'b1;
                slot_unused <= !head_ready;
            end
            if (retire) begin
                unique case (head.code)
                    CODE_VRAM: begin
                        vram_we <= 1'b1;
                        if (head.partial) begin
                            vram_addr <= head.addr ^ ADDR_W'(1);
                            vram_data <= head.value[7:0];
                        end else begin
                            vram_addr <= head.addr;
                            vram_data <= head.value[15:8];
                        end
                    end
                    CODE_CRAM: begin
                        cram_we   <= 1'b1;
                        cram_addr <= cr_idx;
                        cram_data <= head.value;
                    end
                    CODE_VSRAM: begin
                        vsram_we   <= (32'(vs_idx) < VSRAM_WORDS);
                        vsram_addr <= vs_idx;
                        vsram_data <= head.value;
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/vid_write_queue.sv
module vid_write_queue
    import vwq_pkg::*;
#(
    parameter int DEPTH       = 4,
    parameter int LATENCY     = 3,
    parameter int INC_W       = 8,
    parameter int CRAM_WORDS  = 64,
    parameter int VSRAM_WORDS = 40,
    localparam int CRAM_AW    = $clog2(CRAM_WORDS),
    localparam int LVL_W      = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               slot_tick,
    input  logic               h_valid,
    output logic               h_ready,
    input  logic [DATA_W-1:0]  h_data,
    input  logic [CODE_W-1:0]  wr_code,
    input  logic               addr_load,
    input  logic [ADDR_W-1:0]  addr_value,
    input  logic [INC_W-1:0]   auto_inc,
    output logic               vram_we,
    output logic [ADDR_W-1:0]  vram_addr,
    output logic [7:0]         vram_data,
    output logic               cram_we,
    output logic [CRAM_AW-1:0] cram_addr,
    output logic [DATA_W-1:0]  cram_data,
    output logic               vsram_we,
    output logic [IDX_W-1:0]   vsram_addr,
    output logic [DATA_W-1:0]  vsram_data,
    output logic               slot_unused,
    output logic [DATA_W-1:0]  last_value
);
    qent_t              push_ent;
    qent_t              head;
    logic               push;
    logic               pop;
    logic               mark_partial;
    logic               head_valid;
    logic               q_full;
    logic [LVL_W-1:0]   q_level;
    logic [STAMP_W-1:0] slot_cnt;

    vwq_host #(
        .LATENCY (LATENCY),
        .INC_W   (INC_W)
    ) host_i (
        .clk        (clk),
        .rst        (rst),
        .h_valid    (h_valid),
        .h_ready    (h_ready),
        .h_data     (h_data),
        .wr_code    (wr_code),
        .addr_load  (addr_load),
        .addr_value (addr_value),
        .auto_inc   (auto_inc),
        .q_full     (q_full),
        .slot_cnt   (slot_cnt),
        .push       (push),
        .push_ent   (push_ent),
        .last_value (last_value)
    );

    vwq_fifo #(
        .DEPTH (DEPTH)
    ) fifo_i (
        .clk          (clk),
        .rst          (rst),
        .push         (push),
        .push_ent     (push_ent),
        .pop          (pop),
        .mark_partial (mark_partial),
        .head         (head),
        .head_valid   (head_valid),
        .full         (q_full),
        .level        (q_level)
    );

    vwq_retire #(
        .CRAM_WORDS  (CRAM_WORDS),
        .VSRAM_WORDS (VSRAM_WORDS)
    ) retire_i (
        .clk          (clk),
        .rst          (rst),
        .slot_tick    (slot_tick),
        .head         (head),
        .head_valid   (head_valid),
        .pop          (pop),
        .mark_partial (mark_partial),
        .slot_cnt     (slot_cnt),
        .vram_we      (vram_we),
        .vram_addr    (vram_addr),
        .vram_data    (vram_data),
        .cram_we      (cram_we),
        .cram_addr    (cram_addr),
        .cram_data    (cram_data),
        .vsram_we     (vsram_we),
        .vsram_addr   (vsram_addr),
        .vsram_data   (vsram_data),
        .slot_unused  (slot_unused)
    );

endmodule

// File: rtl/vwq_chk.sv
module vwq_chk #(
    parameter int DEPTH = 4,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             slot_tick,
    input logic             h_valid,
    input logic             h_ready,
    input logic [3:0]       wr_code,
    input logic             addr_load,
    input logic             vram_we,
    input logic             cram_we,
    input logic             vsram_we,
    input logic             slot_unused,
    input logic [15:0]      last_value,
    input logic [LVL_W-1:0] q_level
);
    // R11
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vram_we, cram_we, vsram_we}));

    // R11
    strobe_after_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (vram_we || cram_we || vsram_we) |-> $past(slot_tick));

    // R8
    unused_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        slot_unused |-> !(vram_we || cram_we || vsram_we));

    // R8
    unused_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(slot_tick) |-> $stable(slot_unused));

    // R9
    level_bound_chk: assert property (@(posedge clk) disable iff (rst)
        q_level <= LVL_W'(DEPTH));

    // R9
    stall_means_full_chk: assert property (@(posedge clk) disable iff (rst)
        !h_ready |-> (q_level == LVL_W'(DEPTH)));

    // R2
    read_code_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (h_valid && !wr_code[0] && !addr_load) |=> $stable(last_value));

endmodule

bind vid_write_queue vwq_chk #(.DEPTH(DEPTH)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .slot_tick   (slot_tick),
    .h_valid     (h_valid),
    .h_ready     (h_ready),
    .wr_code     (wr_code),
    .addr_load   (addr_load),
    .vram_we     (vram_we),
    .cram_we     (cram_we),
    .vsram_we    (vsram_we),
    .slot_unused (slot_unused),
    .last_value  (last_value),
    .q_level     (q_level)
);

// File: tb/vid_write_queue_tb.sv
`timescale 1ns/1ps
module vid_write_queue_tb_top;

    localparam int K_IDLE  = 0;
    localparam int K_VRAM  = 1;
    localparam int K_CRAM  = 2;
    localparam int K_VSRAM = 3;
    localparam int K_BUSY  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        slot_tick = 1'b0;
    logic        h_valid = 1'b0;
    logic        h_ready;
    logic [15:0] h_data = '0;
    logic [3:0]  wr_code = 4'h1;
    logic        addr_load = 1'b0;
    logic [15:0] addr_value = '0;
    logic [7:0]  auto_inc = 8'd2;
    logic        vram_we;
    logic [15:0] vram_addr;
    logic [7:0]  vram_data;
    logic        cram_we;
    logic [5:0]  cram_addr;
    logic [15:0] cram_data;
    logic        vsram_we;
    logic [5:0]  vsram_addr;
    logic [15:0] vsram_data;
    logic        slot_unused;
    logic [15:0] last_value;

    int n_checks = 0;
    int n_fails  = 0;
    logic [15:0] exp_addr = '0;
    logic [15:0] exp_last = '0;

    always #2 clk = ~clk;

    vid_write_queue dut_i (
        .clk(clk), .rst(rst), .slot_tick(slot_tick),
        .h_valid(h_valid), .h_ready(h_ready), .h_data(h_data),
        .wr_code(wr_code), .addr_load(addr_load), .addr_value(addr_value),
        .auto_inc(auto_inc),
        .vram_we(vram_we), .vram_addr(vram_addr), .vram_data(vram_data),
        .cram_we(cram_we), .cram_addr(cram_addr), .cram_data(cram_data),
        .vsram_we(vsram_we), .vsram_addr(vsram_addr), .vsram_data(vsram_data),
        .slot_unused(slot_unused), .last_value(last_value)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic set_addr(input logic [15:0] a);
        @(negedge clk);
        addr_load  = 1'b1;
        addr_value = a;
        @(posedge clk);
        #1;
        addr_load = 1'b0;
        exp_addr  = a;
    endtask

    task automatic hwrite(input logic [3:0] code, input logic [15:0] d);
        @(negedge clk);
        wr_code = code;
        h_data  = d;
        h_valid = 1'b1;
        while (!h_ready) @(negedge clk);
        @(posedge clk);
        #1;
        h_valid = 1'b0;
        if (code[0]) begin
            exp_last = d;
            exp_addr = exp_addr + {8'h00, auto_inc};
        end
    endtask

    // One slot pulse; outputs are compared just after the slot edge.
    task automatic slot(input int kind, input logic [15:0] a, input logic [15:0] d,
                        input string req);
        logic [3:0] flags;
        @(negedge clk);
        slot_tick = 1'b1;
        @(posedge clk);
        #1;
        slot_tick = 1'b0;
        flags = {vram_we, cram_we, vsram_we, slot_unused};
        case (kind)
            K_IDLE:  chk(flags == 4'b0001, req, "idle slot flags", 32'(flags), 32'h1);
            K_BUSY:  chk(flags == 4'b0000, req, "used slot without write", 32'(flags), 32'h0);
            K_VRAM:  chk(flags == 4'b1000 && vram_addr == a && vram_data == d[7:0], req,
                         "video byte write", {flags, 4'h0, vram_addr, vram_data},
                         {4'b1000, 4'h0, a, d[7:0]});
            K_CRAM:  chk(flags == 4'b0100 && cram_addr == a[5:0] && cram_data == d, req,
                         "color write", {flags, 6'h0, cram_addr, cram_data},
                         {4'b0100, 6'h0, a[5:0], d});
            default: chk(flags == 4'b0010 && vsram_addr == a[5:0] && vsram_data == d, req,
                         "scroll write", {flags, 6'h0, vsram_addr, vsram_data},
                         {4'b0010, 6'h0, a[5:0], d});
        endcase
    endtask

    function automatic logic [15:0] word_idx(input logic [15:0] a);
        return (a >> 1) & 16'h003F;
    endfunction

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(h_ready == 1'b1, "R1", "h_ready", 32'(h_ready), 1);
        chk(slot_unused == 1'b0, "R1", "slot_unused", 32'(slot_unused), 0);
        chk(last_value == 16'h0, "R1", "last_value", 32'(last_value), 0);
        chk({vram_we, cram_we, vsram_we} == 3'b000, "R1", "strobes",
            32'({vram_we, cram_we, vsram_we}), 0);
        slot(K_IDLE, 0, 0, "R8");

        // R4 R5 R10: video RAM words, each retires over the 3rd and 4th slot
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a;
            logic [15:0] d;
            a = 16'h0F00 + 16'(i * 37);
            d = 16'hA500 ^ 16'(i * 16'h0123);
            set_addr(a);
            hwrite(4'h1, d);
            chk(last_value == d, "R10", "last_value", 32'(last_value), 32'(d));
            slot(K_IDLE, 0, 0, "R4");
            slot(K_IDLE, 0, 0, "R4");
            slot(K_VRAM, a, {8'h00, d[15:8]}, "R5");
            slot(K_VRAM, a ^ 16'h0001, d, "R5");
            slot(K_IDLE, 0, 0, "R8");
        end

        // R6: color RAM words, index wraps at 64 words
        for (int i = 0; i < 16; i++) begin
            logic [15:0] a;
            logic [15:0] d;
            a = 16'(i * 16'h00A3 + 1);
            d = 16'h0E00 + 16'(i * 7);
            set_addr(a);
            hwrite(4'h3, d);
            slot(K_IDLE, 0, 0, "R4");
            slot(K_IDLE, 0, 0, "R4");
            slot(K_CRAM, word_idx(a), d, "R6");
            slot(K_IDLE, 0, 0, "R8");
        end

        // R7: scroll RAM index sweep across the 40-word limit
        for (int i = 0; i < 64; i++) begin
            logic [15:0] a;
            logic [15:0] d;
            a = 16'(i * 2 + (i % 2));
            d = 16'h3000 + 16'(i);
            set_addr(a);
            hwrite(4'h5, d);
            slot(K_IDLE, 0, 0, "R4");
            slot(K_IDLE, 0, 0, "R4");
            if (i < 40) slot(K_VSRAM, 16'(i), d, "R7");
            else        slot(K_BUSY, 0, 0, "R7");
        end

        // R3: streaming with odd step, then address wrap
        auto_inc = 8'd3;
        set_addr(16'h0040);
        hwrite(4'h3, 16'h1111);
        hwrite(4'h3, 16'h2222);
        hwrite(4'h3, 16'h3333);
        chk(exp_addr == 16'h0049, "R3", "bench address model", 32'(exp_addr), 32'h49);
        slot(K_IDLE, 0, 0, "R4");
        slot(K_IDLE, 0, 0, "R4");
        slot(K_CRAM, word_idx(16'h0040), 16'h1111, "R3");
        slot(K_CRAM, word_idx(16'h0043), 16'h2222, "R3");
        slot(K_CRAM, word_idx(16'h0046), 16'h3333, "R11");
        auto_inc = 8'd4;
        set_addr(16'hFFFE);
        hwrite(4'h1, 16'hBEEF);
        hwrite(4'h1, 16'hCAFE);
        slot(K_IDLE, 0, 0, "R4");
        slot(K_IDLE, 0, 0, "R4");
        slot(K_VRAM, 16'hFFFE, 16'h00BE, "R3");
        slot(K_VRAM, 16'hFFFF, 16'h00EF, "R3");
        slot(K_VRAM, 16'h0002, 16'h00CA, "R3");
        slot(K_VRAM, 16'h0003, 16'h00FE, "R3");
        slot(K_IDLE, 0, 0, "R8");

        // R2: read code is discarded, address stays put
        auto_inc = 8'd2;
        set_addr(16'h0010);
        hwrite(4'h3, 16'h5A5A);
        hwrite(4'h0, 16'h7777);
        chk(last_value == 16'h5A5A, "R2", "last_value after read code",
            32'(last_value), 32'h5A5A);
        hwrite(4'h3, 16'h6B6B);
        slot(K_IDLE, 0, 0, "R4");
        slot(K_IDLE, 0, 0, "R4");
        slot(K_CRAM, word_idx(16'h0010), 16'h5A5A, "R2");
        slot(K_CRAM, word_idx(16'h0012), 16'h6B6B, "R2");
        slot(K_IDLE, 0, 0, "R2");

        // R12: other odd code uses its slot without writing
        hwrite(4'h7, 16'h0F0F);
        slot(K_IDLE, 0, 0, "R4");
        slot(K_IDLE, 0, 0, "R4");
        slot(K_BUSY, 0, 0, "R12");
        slot(K_IDLE, 0, 0, "R12");

        // R9: fill the queue, observe stall, drain in order
        set_addr(16'h0000);
        for (int i = 0; i < 4; i++) hwrite(4'h3, 16'hC000 + 16'(i));
        @(negedge clk);
        wr_code = 4'h3;
        chk(h_ready == 1'b0, "R9", "h_ready when full", 32'(h_ready), 0);
        slot(K_IDLE, 0, 0, "R9");
        slot(K_IDLE, 0, 0, "R9");
        chk(h_ready == 1'b0, "R9", "h_ready still full", 32'(h_ready), 0);
        slot(K_CRAM, 16'd0, 16'hC000, "R9");
        chk(h_ready == 1'b1, "R9", "h_ready after pop", 32'(h_ready), 1);
        hwrite(4'h3, 16'hC004);
        slot(K_CRAM, 16'd1, 16'hC001, "R11");
        slot(K_CRAM, 16'd2, 16'hC002, "R11");
        slot(K_CRAM, 16'd3, 16'hC003, "R11");
        slot(K_CRAM, 16'd4, 16'hC004, "R9");
        slot(K_IDLE, 0, 0, "R8");
        chk(last_value == exp_last, "R10", "last_value final", 32'(last_value), 32'(exp_last));

        finish_run();
    end

endmodule